// File: doc/BRIEF.md
# Microstep Sequencer for Two-Winding Stepper Drives

This block turns a step clock and a direction level, as issued by an external motion controller, into the drive settings for two microstepping power stages. It tracks a position index into a current-profile table of 2×N eight-bit magnitude codes and a two-bit polarity state. Each qualified step edge moves both by one microstep, forward or backward. A single magnitude code is shared by both stages, and a separate polarity bit goes to each winding.

Both inputs are taken through two-flop synchronizers. A step counts only on a low-to-high transition that was preceded by an observed low level. The direction level is read in the same cycle that the edge is recognised. The polarity state moves only where the index crosses the middle of the table or wraps around its end, and this holds in both directions. The new magnitude code, the new polarity bits and a one-cycle completion strobe are all loaded by the same register stage. Every branch of the update therefore shows the same latency. The profile is a parameter: when it is left at zero, a built-in half-wave parabola is used.

Top module: `ustep_sequencer`

## Requirements
- R1: While reset is asserted, and directly after it, the index and the polarity state are 0. The outputs show the profile code at index 0, `pol_o` = 2'b01 and `step_done_o` = 0.
- R2: A step is taken only on a rising step level that follows a synchronized low level. A step input held high through and after reset produces no step until it has gone low.
- R3: With the direction input high, a step increments the index, and the index always stays below 2×N.
- R4: With the direction input low, a step decrements the index.
- R5: A forward step from index 2×N−1 goes to index 0 and advances the polarity state by one, modulo 4.
- R6: A forward step from index N to N+1 advances the polarity state by one. Every other non-wrapping forward step leaves the polarity state unchanged.
- R7: A backward step from index 0 goes to index 2×N−1 and a backward step from N+1 to N; each retreats the polarity state by one, modulo 4. No other backward step changes it.
- R8: `pol_o` is {winding2, winding1}. It reads 01 for polarity state 0, 11 for state 1, 10 for state 2 and 00 for state 3, and the state changes by at most one per step.
- R9: The outputs update on the third rising clock edge after the step input rises, whatever branch is taken. `step_done_o` is high for exactly that one cycle, and the outputs change at no other time.
- R10: `dac_code_o` equals the profile entry at the current index. The built-in profile is floor(P·4·j·(N−j)/N²), where j = index mod N and P = 2^CODE_W − 1.
- R11: A step input held high yields exactly one step.
- R12: Changes of the direction input while no step edge occurs leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Asynchronous step clock; rising edge after a low moves one microstep |
| dir_i | input | 1 | Asynchronous direction level; 1 forward, 0 backward |
| dac_code_o | output | CODE_W (8) | Current-magnitude code shared by both power stages |
| pol_o | output | 2 | Winding polarity bits {winding2, winding1} |
| step_done_o | output | 1 | One-cycle strobe when the outputs take a new step |

## Verification
A wrong index shows up at `dac_code_o` on the very next update, because it selects a different magnitude code. A polarity state that moves at the wrong place, or stays put at a boundary, shows up at `pol_o` in the update cycle of the crossing step. It then stays wrong for as long as the index is in that half-period. A mistaken edge qualifier shows up as extra or missing `step_done_o` pulses. A latency error shows up as outputs changing one cycle early or late relative to the third clock edge after the step rises. The bench therefore checks the outputs both one cycle before and in the expected update cycle, on every step. Its walks cross the midpoint and both wrap points in each direction.

// File: rtl/ustep_pkg.sv
`timescale 1ns/1ps
package ustep_pkg;

  // Next index on the ring of 2*n positions.
  function automatic int next_index(int idx, bit fwd, int n);
    int last;
    last = 2 * n - 1;
    if (fwd) return (idx == last) ? 0 : idx + 1;
    else     return (idx == 0) ? last : idx - 1;
  endfunction

  // True when this move crosses the midpoint or the wrap point.
  function automatic bit polarity_moves(int idx, bit fwd, int n);
    if (fwd) return (idx == 2 * n - 1) || (idx == n);
    else     return (idx == 0) || (idx == n + 1);
  endfunction

  // Polarity state to winding bits {w2, w1}.
  function automatic logic [1:0] winding_bits(logic [1:0] st);
    logic [1:0] b;
    case (st)
      2'd0:    b = 2'b01;
      2'd1:    b = 2'b11;
      2'd2:    b = 2'b10;
      default: b = 2'b00;
    endcase
    return b;
  endfunction

  // Built-in half-wave parabola profile entry.
  function automatic int parabola_code(int idx, int n, int peak);
    int j;
    j = idx % n;
    return (peak * 4 * j * (n - j)) / (n * n);
  endfunction

endpackage

// File: rtl/ustep_sync.sv
`timescale 1ns/1ps
module ustep_sync #(
  parameter int         W   = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST[b];
        stab_q <= RST[b];
      end else begin
        meta_q <= async_i[b];
        stab_q <= meta_q;
      end
    end
    assign sync_o[b] = stab_q;
  end
endmodule

// File: rtl/ustep_edge.sv
`timescale 1ns/1ps
module ustep_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic evt_o
);
  logic armed_q;

  assign evt_o = lvl_i & armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (!lvl_i) armed_q <= 1'b1;
    else if (evt_o)  armed_q <= 1'b0;
  end

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o); // R11

  AST_EVT_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_o) |-> $past(armed_q) || $past(!lvl_i)); // R2
endmodule

// File: rtl/ustep_pos.sv
`timescale 1ns/1ps
module ustep_pos #(
  parameter int HALF_STEPS = 60,
  localparam int DEPTH = 2 * HALF_STEPS,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             fwd_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [1:0]       pol_o,
  output logic [IDX_W-1:0] idx_nxt_o,
  output logic [1:0]       pol_nxt_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);
  localparam logic [IDX_W-1:0] IDX_MID  = IDX_W'(HALF_STEPS);
  localparam logic [IDX_W-1:0] IDX_MID1 = IDX_W'(HALF_STEPS + 1);

  logic [IDX_W-1:0] idx_q;
  logic [1:0]       pol_q;
  logic             pol_move;
  logic             wrap_fwd, wrap_bwd;

  assign wrap_fwd  = fwd_i  && (idx_q == IDX_LAST);
  assign wrap_bwd  = !fwd_i && (idx_q == '0);
  assign pol_move  = ustep_pkg::polarity_moves(int'(idx_q), fwd_i, HALF_STEPS);
  assign idx_nxt_o = IDX_W'(ustep_pkg::next_index(int'(idx_q), fwd_i, HALF_STEPS));
  assign pol_nxt_o = !pol_move ? pol_q : (fwd_i ? pol_q + 2'd1 : pol_q - 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      pol_q <= 2'd0;
    end else if (evt_i) begin
      idx_q <= idx_nxt_o;
      pol_q <= pol_nxt_o;
    end
  end

  assign idx_o = idx_q;
  assign pol_o = pol_q;

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_LAST); // R3

  AST_POL_MOVES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    2'(pol_q - $past(pol_q)) != 2'd2); // R8

  AST_POL_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_q != $past(pol_q)) |->
      (idx_q == '0 || idx_q == IDX_LAST || idx_q == IDX_MID || idx_q == IDX_MID1)); // R6

  AST_WRAP_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && wrap_fwd) |=> (idx_q == '0) && (pol_q == $past(pol_q) + 2'd1)); // R5

  AST_WRAP_BWD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && wrap_bwd) |=> (idx_q == IDX_LAST) && (pol_q == $past(pol_q) - 2'd1)); // R7

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(evt_i) |-> $stable(idx_q) && $stable(pol_q)); // R12
endmodule

// File: rtl/ustep_rom.sv
`timescale 1ns/1ps
module ustep_rom #(
  parameter int HALF_STEPS = 60,
  parameter int CODE_W     = 8,
  localparam int DEPTH = 2 * HALF_STEPS,
  localparam int IDX_W = $clog2(DEPTH),
  parameter logic [DEPTH*CODE_W-1:0] PROFILE = '0
) (
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [CODE_W-1:0] rd_code_o,
  output logic [CODE_W-1:0] home_code_o
);
  localparam int PEAK = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] table_w [DEPTH];

  if (PROFILE == '0) begin : g_builtin
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      assign table_w[e] = CODE_W'(ustep_pkg::parabola_code(e, HALF_STEPS, PEAK));
    end
  end else begin : g_param
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      assign table_w[e] = PROFILE[e*CODE_W +: CODE_W];
    end
  end

  assign rd_code_o   = (int'(rd_idx_i) < DEPTH) ? table_w[rd_idx_i] : '0;
  assign home_code_o = table_w[0];
endmodule

// File: rtl/ustep_sequencer.sv
`timescale 1ns/1ps
module ustep_sequencer #(
  parameter int HALF_STEPS = 60,
  parameter int CODE_W     = 8,
  localparam int DEPTH = 2 * HALF_STEPS,
  localparam int IDX_W = $clog2(DEPTH),
  parameter logic [DEPTH*CODE_W-1:0] PROFILE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              dir_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic [1:0]        pol_o,
  output logic              step_done_o
);
  logic [1:0]        sync_w;
  logic              step_evt;
  logic [IDX_W-1:0]  idx_w, idx_nxt_w;
  logic [1:0]        pol_w, pol_nxt_w;
  logic [CODE_W-1:0] code_nxt_w, code_home_w;

  // Step input resets high so a level held through reset is not an edge.
  ustep_sync #(.W(2), .RST(2'b01)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_i({dir_i, step_i}), .sync_o(sync_w)
  );

  ustep_edge edge_i (
    .clk(clk), .rst_n(rst_n), .lvl_i(sync_w[0]), .evt_o(step_evt)
  );

  ustep_pos #(.HALF_STEPS(HALF_STEPS)) pos_i (
    .clk(clk), .rst_n(rst_n), .evt_i(step_evt), .fwd_i(sync_w[1]),
    .idx_o(idx_w), .pol_o(pol_w), .idx_nxt_o(idx_nxt_w), .pol_nxt_o(pol_nxt_w)
  );

  ustep_rom #(.HALF_STEPS(HALF_STEPS), .CODE_W(CODE_W), .PROFILE(PROFILE)) rom_i (
    .rd_idx_i(idx_nxt_w), .rd_code_o(code_nxt_w), .home_code_o(code_home_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code_o  <= code_home_w;
      pol_o       <= ustep_pkg::winding_bits(2'd0);
      step_done_o <= 1'b0;
    end else begin
      step_done_o <= step_evt;
      if (step_evt) begin
        dac_code_o <= code_nxt_w;
        pol_o      <= ustep_pkg::winding_bits(pol_nxt_w);
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    step_done_o |=> !step_done_o); // R9

  AST_OUT_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !step_done_o |-> $stable(dac_code_o) && $stable(pol_o)); // R9

  AST_POL_TRACKS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    step_done_o |-> (pol_o == ustep_pkg::winding_bits(pol_w))); // R8

  AST_DONE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    step_done_o |-> $past(sync_w[0])); // R2
endmodule

// File: tb/ustep_sequencer_tb.sv
`timescale 1ns/1ps
module ustep_sequencer_tb_top;
  localparam int N = 60;
  localparam int DEPTH = 2 * N;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_i = 1'b1;
  logic       dir_i = 1'b1;
  logic [7:0] dac_code_o;
  logic [1:0] pol_o;
  logic       step_done_o;

  int checks = 0;
  int fails = 0;
  int done_cnt = 0;
  int m_idx = 0;
  int m_pol = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ustep_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .dir_i(dir_i),
    .dac_code_o(dac_code_o), .pol_o(pol_o), .step_done_o(step_done_o)
  );

  always @(posedge clk) if (step_done_o) done_cnt <= done_cnt + 1;

  // Expected profile: 255 * 4j(N-j) / N^2, j = index mod N.
  function automatic int exp_code(int i);
    int j;
    j = i - ((i >= N) ? N : 0);
    return (1020 * j * (N - j)) / (N * N);
  endfunction

  function automatic int exp_pol(int s);
    int bits [4] = '{1, 3, 2, 0};
    return bits[s & 3];
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_neg(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // One step with model update and latency checks around the update cycle.
  task automatic step_once(bit fwd);
    int old_idx, old_pol;
    string tag;
    old_idx = m_idx;
    old_pol = m_pol;
    tag = fwd ? "R3" : "R4";
    if (fwd) begin
      if (m_idx == DEPTH - 1) begin m_idx = 0; m_pol++; tag = "R5"; end
      else begin
        if (m_idx == N) begin m_pol++; tag = "R6"; end
        m_idx++;
      end
    end else begin
      if (m_idx == 0) begin m_idx = DEPTH - 1; m_pol--; tag = "R7"; end
      else begin
        if (m_idx == N + 1) begin m_pol--; tag = "R7"; end
        m_idx--;
      end
    end
    m_pol = m_pol & 3;
    @(negedge clk);
    dir_i  = fwd;
    step_i = 1'b1;
    wait_neg(2);
    chk("R9 early dac", int'(dac_code_o), exp_code(old_idx));
    chk("R9 early pol", int'(pol_o), exp_pol(old_pol));
    chk("R9 early done", int'(step_done_o), 0);
    wait_neg(1);
    chk({tag, " R10 dac"}, int'(dac_code_o), exp_code(m_idx));
    chk({tag, " R8 pol"}, int'(pol_o), exp_pol(m_pol));
    chk("R9 done", int'(step_done_o), 1);
    step_i = 1'b0;
    wait_neg(3);
  endtask

  // Vectors: {direction, step count}.
  localparam logic [8:0] VECS [7] = '{
    {1'b1, 8'd70}, {1'b0, 8'd75}, {1'b1, 8'd10}, {1'b0, 8'd3},
    {1'b1, 8'd2},  {1'b0, 8'd62}, {1'b1, 8'd1}
  };

  initial begin
    wait_neg(5);
    chk("R1 reset dac", int'(dac_code_o), exp_code(0));
    chk("R1 reset pol", int'(pol_o), 1);
    chk("R1 reset done", int'(step_done_o), 0);
    rst_n = 1'b1;
    wait_neg(8);
    chk("R2 held-high no step", done_cnt, 0);
    chk("R2 held-high dac", int'(dac_code_o), exp_code(0));
    step_i = 1'b0;
    wait_neg(4);
    step_i = 1'b1;
    wait_neg(4);
    chk("R2 first edge counted", done_cnt, 1);
    chk("R3 first step dac", int'(dac_code_o), exp_code(1));
    wait_neg(20);
    chk("R11 held high one step", done_cnt, 1);
    chk("R11 held high dac", int'(dac_code_o), exp_code(1));
    step_i = 1'b0;
    m_idx = 1;
    wait_neg(4);
    for (int k = 0; k < 10; k++) begin
      dir_i = ~dir_i;
      wait_neg(3);
    end
    chk("R12 dir toggles count", done_cnt, 1);
    chk("R12 dir toggles dac", int'(dac_code_o), exp_code(1));
    chk("R12 dir toggles pol", int'(pol_o), 1);

    foreach (VECS[v]) begin
      for (int s = 0; s < int'(VECS[v][7:0]); s++) step_once(VECS[v][8]);
    end

    // Back-and-forth around the midpoint and the wrap.
    while (m_idx != N + 1) step_once(1'b1);
    step_once(1'b0);
    step_once(1'b1);
    while (m_idx != 0) step_once(1'b1);
    step_once(1'b0);
    step_once(1'b1);

    // Reset mid-run returns to home.
    rst_n = 1'b0;
    wait_neg(2);
    rst_n = 1'b1;
    wait_neg(4);
    chk("R1 re-reset dac", int'(dac_code_o), exp_code(0));
    chk("R1 re-reset pol", int'(pol_o), 1);
    m_idx = 0;
    m_pol = 0;
    step_once(1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule